// File: doc/BRIEF.md
# Vector Greater-Than Comparator with Byte Predicate

The block compares two wide vectors lane by lane and decides, for each lane, whether the first operand is strictly greater than the second. A format input picks the lane view. Single precision uses 32-bit lanes and half precision uses 16-bit lanes. Every bit pattern is placed on one total order, so NaN values are never unordered. Positive NaNs sort above +Inf and negative NaNs sort below -Inf. Within each sign, quiet NaNs sort further out than signalling NaNs.

The per-lane decision is spread over a predicate that has one bit per vector byte. This predicate is held in a register. An operation input chooses how a valid request updates the register: it can replace the contents, or merge the new result by AND, OR or XOR. A byte-wise selector uses the registered predicate to build an output vector. Each output byte comes from a "true" source vector where its predicate bit is set, and from a "false" source vector where it is clear.

Top module: `vcmp_top`

## Requirements
- R1: In single-precision format (fmt = 0), lane i is bits [32i+31:32i]. A lane is true only if vec_a is strictly above vec_b on this order: positive QNaN > positive SNaN > +Inf (0x7F800000) > positive finite > negative finite > -Inf (0xFF800000) > negative SNaN > negative QNaN. Quiet NaNs have mantissa MSB set and signalling NaNs have it clear. Among positive values the larger magnitude is greater. Among negative values the smaller magnitude is greater.
- R2: Operands with identical encodings give false, for every encoding, NaNs included.
- R3: In half-precision format (fmt = 1), lane i is bits [16i+15:16i] and the same order applies. Some reference points on it: 0x7E00 > 0x7D00 > 0x7C00 > 0x3C00 > 0xFC00 > 0xFD00 > 0xFE00.
- R4: In single precision, lane i drives predicate bits [4i+3:4i], all four with the lane's result. Lane 0 false and lane 1 true therefore give pred[7:0] = 0xF0.
- R5: In half precision, lane i drives predicate bits [2i+1:2i], both with the lane's result.
- R6: On a clock edge with valid high, op selects the new predicate: op = 0 writes the fresh result, op = 1 writes old AND fresh, op = 2 writes old OR fresh, and op = 3 writes old XOR fresh.
- R7: While valid is low and reset is released, the predicate keeps its value.
- R8: A clock edge with rst_n low clears the predicate to all zeros. This reset is synchronous.
- R9: Byte k of mux_out equals byte k of true_vec when pred[k] is 1, and byte k of false_vec when pred[k] is 0. mux_out follows the registered predicate without delay.
- R10: +0 is greater than -0, and -0 is not greater than +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Request strobe; updates the predicate |
| fmt | input | 1 | Lane format: 0 single, 1 half precision |
| op | input | 2 | Update mode: 0 write, 1 AND, 2 OR, 3 XOR |
| vec_a | input | 1024 | First compare operand |
| vec_b | input | 1024 | Second compare operand |
| true_vec | input | 1024 | Byte source where predicate bit is set |
| false_vec | input | 1024 | Byte source where predicate bit is clear |
| pred | output | 128 | Registered predicate, one bit per byte |
| mux_out | output | 1024 | Byte-wise selection by pred |

## Verification
The assertions run on every cycle and cover the register behaviour:
- reset clears the predicate, and an idle cycle leaves it unchanged;
- after a write, the predicate bits are uniform within each group of four (single) or two (half);
- an AND update never sets a bit and an OR update never clears one;
- mux_out equals the matching source when the predicate is all ones or all zeros.

The ordering itself is checked only by the bench's scenarios. These cover the NaN and infinity ladder, equal encodings, signed zeros, the lane-to-bit placement, and the exact results of the merge modes. The bench checks them with directed vectors and with random lanes that mix in special encodings.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
    localparam int SP_W = 32;
    localparam int HP_W = 16;

    typedef enum logic {
        FMT_SP = 1'b0,
        FMT_HP = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } op_e;
endpackage

// File: rtl/vcmp_lane_gt.sv
module vcmp_lane_gt #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         gt
);
    logic [W-1:0] key_a;
    logic [W-1:0] key_b;

    // Sign-magnitude to monotonic key: positives above, negatives inverted.
    always_comb begin
        key_a = a[W-1] ? {1'b0, ~a[W-2:0]} : {1'b1, a[W-2:0]};
        key_b = b[W-1] ? {1'b0, ~b[W-2:0]} : {1'b1, b[W-2:0]};
        gt    = key_a > key_b;
    end
endmodule

// File: rtl/vcmp_gt_array.sv
module vcmp_gt_array
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = 1024
) (
    input  fmt_e                  fmt,
    input  logic [VEC_BITS-1:0]   vec_a,
    input  logic [VEC_BITS-1:0]   vec_b,
    output logic [VEC_BITS/8-1:0] byte_gt
);
    localparam int NBYTE  = VEC_BITS / 8;
    localparam int NSP    = VEC_BITS / SP_W;
    localparam int NHP    = VEC_BITS / HP_W;
    localparam int SP_BPL = SP_W / 8;
    localparam int HP_BPL = HP_W / 8;

    logic [NSP-1:0] sp_gt;
    logic [NHP-1:0] hp_gt;

    for (genvar i = 0; i < NSP; i++) begin : g_sp
        vcmp_lane_gt #(.W(SP_W)) lane_i (
            .a  (vec_a[i*SP_W +: SP_W]),
            .b  (vec_b[i*SP_W +: SP_W]),
            .gt (sp_gt[i])
        );
    end

    for (genvar i = 0; i < NHP; i++) begin : g_hp
        vcmp_lane_gt #(.W(HP_W)) lane_i (
            .a  (vec_a[i*HP_W +: HP_W]),
            .b  (vec_b[i*HP_W +: HP_W]),
            .gt (hp_gt[i])
        );
    end

    for (genvar j = 0; j < NBYTE; j++) begin : g_expand
        always_comb begin
            unique case (fmt)
                FMT_SP: byte_gt[j] = sp_gt[j / SP_BPL];
                FMT_HP: byte_gt[j] = hp_gt[j / HP_BPL];
                default: byte_gt[j] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vcmp_pred_reg.sv
module vcmp_pred_reg
    import vcmp_pkg::*;
#(
    parameter int PBITS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  op_e              op,
    input  logic [PBITS-1:0] fresh,
    output logic [PBITS-1:0] pred
);
    logic [PBITS-1:0] pred_q;
    logic [PBITS-1:0] pred_d;

    always_comb begin
        unique case (op)
            OP_SET: pred_d = fresh;
            OP_AND: pred_d = pred_q & fresh;
            OP_OR:  pred_d = pred_q | fresh;
            OP_XOR: pred_d = pred_q ^ fresh;
            default: pred_d = fresh;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pred_q <= '0;
        else if (valid)
            pred_q <= pred_d;
    end

    assign pred = pred_q;
endmodule

// File: rtl/vcmp_byte_mux.sv
module vcmp_byte_mux #(
    parameter int VEC_BITS = 1024
) (
    input  logic [VEC_BITS/8-1:0] sel,
    input  logic [VEC_BITS-1:0]   in_t,
    input  logic [VEC_BITS-1:0]   in_f,
    output logic [VEC_BITS-1:0]   out
);
    localparam int NBYTE = VEC_BITS / 8;

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        assign out[k*8 +: 8] = sel[k] ? in_t[k*8 +: 8] : in_f[k*8 +: 8];
    end
endmodule

// File: rtl/vcmp_top.sv
module vcmp_top
    import vcmp_pkg::*;
#(
    parameter int VEC_BITS = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic                  fmt,
    input  logic [1:0]            op,
    input  logic [VEC_BITS-1:0]   vec_a,
    input  logic [VEC_BITS-1:0]   vec_b,
    input  logic [VEC_BITS-1:0]   true_vec,
    input  logic [VEC_BITS-1:0]   false_vec,
    output logic [VEC_BITS/8-1:0] pred,
    output logic [VEC_BITS-1:0]   mux_out
);
    localparam int PBITS = VEC_BITS / 8;

    logic [PBITS-1:0] fresh;

    vcmp_gt_array #(.VEC_BITS(VEC_BITS)) cmp_i (
        .fmt     (fmt_e'(fmt)),
        .vec_a   (vec_a),
        .vec_b   (vec_b),
        .byte_gt (fresh)
    );

    vcmp_pred_reg #(.PBITS(PBITS)) preg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid),
        .op    (op_e'(op)),
        .fresh (fresh),
        .pred  (pred)
    );

    vcmp_byte_mux #(.VEC_BITS(VEC_BITS)) mux_i (
        .sel  (pred),
        .in_t (true_vec),
        .in_f (false_vec),
        .out  (mux_out)
    );
endmodule

// File: rtl/vcmp_chk.sv
module vcmp_chk #(
    parameter int VEC_BITS = 1024
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  valid,
    input logic                  fmt,
    input logic [1:0]            op,
    input logic [VEC_BITS-1:0]   true_vec,
    input logic [VEC_BITS-1:0]   false_vec,
    input logic [VEC_BITS/8-1:0] pred,
    input logic [VEC_BITS-1:0]   mux_out
);
    localparam int PBITS = VEC_BITS / 8;

    function automatic logic groups_ok(logic [PBITS-1:0] p, int g);
        logic ok = 1'b1;
        for (int i = 0; i < PBITS; i++)
            if (p[i] != p[(i / g) * g]) ok = 1'b0;
        return ok;
    endfunction

    // R8
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> pred == '0);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(pred));

    // R4
    sp_quads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fmt && op == 2'd0) |=> groups_ok(pred, 4));

    // R5
    hp_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && fmt && op == 2'd0) |=> groups_ok(pred, 2));

    // R6
    and_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'd1) |=> (pred & ~$past(pred)) == '0);

    // R6
    or_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == 2'd2) |=> ($past(pred) & ~pred) == '0);

    // R9
    mux_all_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&pred) |-> mux_out == true_vec);

    // R9
    mux_all_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred == '0) |-> mux_out == false_vec);
endmodule

bind vcmp_top vcmp_chk #(.VEC_BITS(VEC_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .fmt       (fmt),
    .op        (op),
    .true_vec  (true_vec),
    .false_vec (false_vec),
    .pred      (pred),
    .mux_out   (mux_out)
);

// File: tb/vcmp_top_tb_top.sv
`timescale 1ns/1ps
module vcmp_top_tb_top;
    localparam int VB = 1024;
    localparam int PB = VB / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic          fmt = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [VB-1:0] vec_a = '0, vec_b = '0, true_vec = '0, false_vec = '0;
    logic [PB-1:0] pred;
    logic [VB-1:0] mux_out;

    int checks = 0;
    int fails = 0;
    logic [PB-1:0] model = '0;

    always #10 clk = ~clk;

    vcmp_top #(.VEC_BITS(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid(valid), .fmt(fmt), .op(op),
        .vec_a(vec_a), .vec_b(vec_b), .true_vec(true_vec),
        .false_vec(false_vec), .pred(pred), .mux_out(mux_out)
    );

    function automatic bit ref_gt(bit [31:0] a, bit [31:0] b, int w);
        bit [31:0] mask = (32'h1 << (w - 1)) - 1;
        bit sa = a[w-1];
        bit sb = b[w-1];
        if (sa != sb) return !sa;
        if (!sa) return (a & mask) > (b & mask);
        return (a & mask) < (b & mask);
    endfunction

    function automatic logic [PB-1:0] ref_fresh(bit f, logic [VB-1:0] a, logic [VB-1:0] b);
        logic [PB-1:0] p;
        int w = f ? 16 : 32;
        for (int j = 0; j < PB; j++) begin
            int lane = j / (w / 8);
            bit [31:0] la = 32'(a >> (lane * w));
            bit [31:0] lb = 32'(b >> (lane * w));
            if (w == 16) begin la[31:16] = '0; lb[31:16] = '0; end
            p[j] = ref_gt(la, lb, w);
        end
        return p;
    endfunction

    function automatic logic [VB-1:0] ref_mux(logic [PB-1:0] p);
        logic [VB-1:0] m;
        for (int k = 0; k < PB; k++)
            m[k*8 +: 8] = p[k] ? true_vec[k*8 +: 8] : false_vec[k*8 +: 8];
        return m;
    endfunction

    function automatic bit [31:0] pick(int w);
        int r = int'($urandom % 12);
        if (w == 32) begin
            case (r)
                0: return 32'h7FC00000; 1: return 32'h7FA00000;
                2: return 32'h7F800000; 3: return 32'hFF800000;
                4: return 32'hFFA00000; 5: return 32'hFFC00000;
                6: return 32'h00000000; 7: return 32'h80000000;
                default: return $urandom;
            endcase
        end
        case (r)
            0: return 32'h7E00; 1: return 32'h7D00; 2: return 32'h7C00;
            3: return 32'hFC00; 4: return 32'hFD00; 5: return 32'hFE00;
            6: return 32'h0000; 7: return 32'h8000;
            default: return {16'h0, 16'($urandom)};
        endcase
    endfunction

    task automatic check_pred(string tag, logic [PB-1:0] exp);
        checks++;
        if (pred !== exp) begin
            fails++;
            $display("FAIL %s pred act=%h exp=%h", tag, pred, exp);
        end
        checks++;
        if (mux_out !== ref_mux(exp)) begin
            fails++;
            $display("FAIL %s mux_out act=%h exp=%h", tag, mux_out, ref_mux(exp));
        end
    endtask

    // Drive at negedge, update at posedge, sample at next negedge.
    task automatic apply(bit v, bit f, bit [1:0] o, logic [VB-1:0] a, logic [VB-1:0] b, string tag);
        logic [PB-1:0] fr;
        @(negedge clk);
        valid = v; fmt = f; op = o; vec_a = a; vec_b = b;
        fr = ref_fresh(f, a, b);
        if (v) begin
            case (o)
                2'd0: model = fr;
                2'd1: model = model & fr;
                2'd2: model = model | fr;
                default: model = model ^ fr;
            endcase
        end
        @(posedge clk);
        #1 valid = 1'b0;
        @(negedge clk);
        check_pred(tag, model);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [VB-1:0] a, b;
        bit [31:0] sp_ladder [7];
        bit [15:0] hp_ladder [7];
        void'($urandom(32'd20240611));
        sp_ladder = '{32'h7FC00000, 32'h7FA00000, 32'h7F800000, 32'h3F800000,
                      32'hFF800000, 32'hFFA00000, 32'hFFC00000};
        hp_ladder = '{16'h7E00, 16'h7D00, 16'h7C00, 16'h3C00,
                      16'hFC00, 16'hFD00, 16'hFE00};
        for (int k = 0; k < VB / 32; k++) begin
            true_vec[k*32 +: 32] = $urandom;
            false_vec[k*32 +: 32] = $urandom;
        end

        // R8: reset clears
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_pred("R8 reset", '0);
        rst_n = 1'b1;

        // R4: lane0 false, lane1 true -> byte 0 = F0
        a = '0; b = '0;
        a[31:0] = 32'h00000000; b[31:0] = 32'h3F800000;
        a[63:32] = 32'h3F800000; b[63:32] = 32'h00000000;
        apply(1, 0, 2'd0, a, b, "R4 lane placement");
        checks++;
        if (pred[7:0] !== 8'hF0) begin fails++; $display("FAIL R4 byte0 act=%h exp=f0", pred[7:0]); end

        // R6: accumulate examples
        true_vec = '1; false_vec = '0;
        apply(1, 0, 2'd1, a, b, "R6 and");
        checks++;
        if (pred[7:0] !== 8'hF0) begin fails++; $display("FAIL R6 and act=%h exp=f0", pred[7:0]); end
        checks++;
        if (mux_out[63:0] !== 64'hFFFFFFFF_00000000) begin
            fails++; $display("FAIL R9 mask act=%h exp=ffffffff00000000", mux_out[63:0]);
        end
        apply(1, 0, 2'd3, a, b, "R6 xor self");
        checks++;
        if (pred !== '0) begin fails++; $display("FAIL R6 xor act=%h exp=0", pred); end
        apply(1, 0, 2'd2, a, b, "R6 or");
        apply(1, 0, 2'd0, '0, '0, "R2 zero equal");

        // R7: valid low ignored, then held
        apply(1, 0, 2'd0, a, b, "R7 setup");
        apply(0, 0, 2'd0, b, a, "R7 idle hold");
        apply(0, 1, 2'd3, '1, '0, "R7 idle hold op");

        // R1/R3: ladder in lanes, forward true, reversed false
        a = '0; b = '0;
        for (int i = 0; i < 6; i++) begin
            a[i*32 +: 32] = sp_ladder[i]; b[i*32 +: 32] = sp_ladder[i+1];
            a[(i+8)*32 +: 32] = sp_ladder[i+1]; b[(i+8)*32 +: 32] = sp_ladder[i];
        end
        apply(1, 0, 2'd0, a, b, "R1 sp ladder");
        checks++;
        if (pred[23:0] !== 24'hFFFFFF || pred[55:32] !== 24'h0) begin
            fails++; $display("FAIL R1 ladder act=%h exp=ffffff/0", pred[55:0]);
        end
        a = '0; b = '0;
        for (int i = 0; i < 6; i++) begin
            a[i*16 +: 16] = hp_ladder[i]; b[i*16 +: 16] = hp_ladder[i+1];
            a[(i+8)*16 +: 16] = hp_ladder[i+1]; b[(i+8)*16 +: 16] = hp_ladder[i];
        end
        apply(1, 1, 2'd0, a, b, "R3 hp ladder");
        checks++;
        if (pred[11:0] !== 12'hFFF || pred[27:16] !== 12'h0) begin
            fails++; $display("FAIL R3 R5 ladder act=%h exp=fff/0", pred[27:0]);
        end

        // R2: identical encodings incl SNaN; R10: signed zeros
        a = '0; b = '0;
        a[31:0] = 32'h7FA00000; b[31:0] = 32'h7FA00000;
        a[63:32] = 32'h400CCCCD; b[63:32] = 32'h400CCCCD;
        a[95:64] = 32'h00000000; b[95:64] = 32'h80000000;
        a[127:96] = 32'h80000000; b[127:96] = 32'h00000000;
        apply(1, 0, 2'd0, a, b, "R2 R10 sp");
        checks++;
        if (pred[15:0] !== 16'h0F00) begin fails++; $display("FAIL R2 R10 act=%h exp=0f00", pred[15:0]); end
        a = '0; b = '0;
        a[15:0] = 16'h7D00; b[15:0] = 16'h7D00;
        a[31:16] = 16'h0000; b[31:16] = 16'h8000;
        a[47:32] = 16'h8000; b[47:32] = 16'h0000;
        apply(1, 1, 2'd0, a, b, "R2 R10 hp");
        checks++;
        if (pred[5:0] !== 6'b001100) begin fails++; $display("FAIL R2 R10 hp act=%b exp=001100", pred[5:0]); end

        // Random mix, R1 R3 R5 R6
        for (int n = 0; n < 300; n++) begin
            bit f = 1'($urandom);
            int w = f ? 16 : 32;
            for (int l = 0; l < VB / w; l++) begin
                bit [31:0] x = pick(w);
                bit [31:0] y = ($urandom % 8 == 0) ? x : pick(w);
                a[l*w +: 16] = x[15:0]; b[l*w +: 16] = y[15:0];
                if (w == 32) begin a[l*w+16 +: 16] = x[31:16]; b[l*w+16 +: 16] = y[31:16]; end
            end
            for (int k = 0; k < VB / 32; k++) begin
                true_vec[k*32 +: 32] = $urandom;
                false_vec[k*32 +: 32] = $urandom;
            end
            apply(1'($urandom % 5 != 0), f, 2'($urandom), a, b, "R1 R3 R6 R9 random");
        end

        // R8: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); model = '0;
        check_pred("R8 reset again", '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule